// File: doc/BRIEF.md
# Hot-Insertion Bus Join Sequencer

This block decides when an upstream two-wire bus segment (the master side) and a downstream segment (the translated-slave side) may be electrically joined, and it signals readiness to the rest of the system. While it is held off, by a low enable or by a raised undervoltage flag, every link is open. The stored translation byte is zero, translation is off, and the ready output is low.

When the block is allowed to run, it asks an external sampler for the 7-bit translation byte through a request/acknowledge pair and keeps the captured value. It then watches both segments until each one is quiet. A segment counts as quiet when a STOP condition is seen on it, or when both of its lines have stayed high for a programmable time (nominally 120 µs). Only then are the clock and data links closed, and ready rises in the same cycle. The enable input, the undervoltage flag and the four bus lines are synchronized to the system clock. Driving enable high, then low, then high again repeats the whole sequence and picks up a fresh byte. This lets a card be inserted into a live bus without corrupting a transfer in flight.

Top module: `bus_join_seq`

## Requirements
- R1: After reset, `scl_link_o`, `sda_link_o`, `xlat_en_o`, `ready_o` and `cfg_req_o` are 0 and `xlat_byte_o` is 0.
- R2: Once enable is high and the undervoltage flag is clear, `cfg_req_o` rises and stays high until a cycle in which `cfg_ack_i` is 1.
- R3: The value on `cfg_byte_i` in the acknowledge cycle appears on `xlat_byte_o` and stays unchanged until the next shutdown, whatever `cfg_byte_i` or `cfg_ack_i` do afterwards.
- R4: `scl_link_o`, `sda_link_o`, `xlat_en_o` and `ready_o` rise together, and only after the byte has been captured and both segments are quiet.
- R5: A STOP on a segment (SDA rising while SCL is high) makes that segment quiet at once, without waiting for the timer.
- R6: A segment becomes quiet after both its lines have been high for `IDLE_US` microseconds of the system clock. A low on either line restarts this count.
- R7: A START on a segment (SDA falling while SCL is high) withdraws that segment's quiet status, so the links stay open.
- R8: Within four clock cycles of enable going low or the undervoltage flag going high, all links are open, translation is off, ready is low and `xlat_byte_o` is 0.
- R9: Driving enable high, low and high again repeats the sequence, and the new byte replaces the old one.
- R10: When the undervoltage flag clears while enable is held high, the sequence restarts with a new configuration request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Asynchronous enable |
| uv_i | input | 1 | Asynchronous undervoltage flag, high means the supply is too low |
| scl_up_i | input | 1 | Upstream clock line level |
| sda_up_i | input | 1 | Upstream data line level |
| scl_dn_i | input | 1 | Downstream clock line level |
| sda_dn_i | input | 1 | Downstream data line level |
| cfg_req_o | output | 1 | Asks the sampler for the translation byte |
| cfg_ack_i | input | 1 | Sampler reports `cfg_byte_i` is valid |
| cfg_byte_i | input | 7 | Translation byte from the sampler |
| xlat_byte_o | output | 7 | Captured translation byte, zero while shut down |
| xlat_en_o | output | 1 | Permits the translator and its SDA driver to act |
| scl_link_o | output | 1 | Closes the clock link between the segments |
| sda_link_o | output | 1 | Closes the data link between the segments |
| ready_o | output | 1 | High while the segments are joined |

## Verification
The bench builds the block with `CLK_HZ` = 1 000 000 and `IDLE_US` = 16, so the quiet timer lasts 16 cycles. This puts the timer expiry, its restart after a brief low, and the race between the timer and a STOP within a few dozen cycles. At the default settings the timer runs for 24 000 cycles, and the bench instead brackets the expiry with checks taken before and after it.

// File: rtl/bus_join_seq_pkg.sv
// Shared types for the bus join sequencer.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package bus_join_seq_pkg;
    typedef enum logic [1:0] {
        SQ_OFF  = 2'd0,   // shut down, links open
        SQ_CFG  = 2'd1,   // waiting on the configuration sampler
        SQ_WAIT = 2'd2,   // waiting for both segments to go quiet
        SQ_ON   = 2'd3    // segments joined
    } seq_state_t;
endpackage

// File: rtl/bjs_sync.sv
// Multi-stage synchronizer bank for asynchronous level inputs.
// Assumes each bit is independent; no bus coherency is implied.
module bjs_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Shift each stage one step toward the output.
            always_ff @(posedge clk) begin
                if (!rst_n)      stg[s] <= RST_VAL;
                else if (s == 0) stg[s] <= d_i;
                else             stg[s] <= stg[(s > 0) ? s - 1 : 0];
            end
        end
    endgenerate

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/bjs_seg_idle.sv
// Quiet detector for one two-wire bus segment.
// Marks the segment quiet on a STOP, or after IDLE_CYC cycles with both lines high.
// A START withdraws the mark. clr_i discards all history.
// Assumes synchronized line inputs.
module bjs_seg_idle #(
    parameter int IDLE_CYC = 16,
    localparam int CW      = $clog2(IDLE_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic scl_i,
    input  logic sda_i,
    output logic idle_o
);
    logic          scl_q, sda_q;
    logic [CW-1:0] cnt;
    logic          start_det, stop_det, lines_hi;

    assign lines_hi  = scl_i && sda_i;
    assign start_det = scl_q && scl_i && sda_q && !sda_i;
    assign stop_det  = scl_q && scl_i && !sda_q && sda_i;

    // Remember the previous line levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    // Count consecutive cycles with both lines high, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i || !lines_hi) cnt <= '0;
        else if (cnt != CW'(IDLE_CYC))    cnt <= cnt + 1'b1;
    end

    // Sticky quiet flag: set by a STOP or by timer expiry, cleared by a START.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)                               idle_o <= 1'b0;
        else if (start_det)                                idle_o <= 1'b0;
        else if (stop_det || (lines_hi && cnt == CW'(IDLE_CYC - 1)))
                                                           idle_o <= 1'b1;
    end

    a_r5_stop_marks_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !clr_i) |=> idle_o);
    a_r6_low_restarts_count: assert property (@(posedge clk) disable iff (!rst_n)
        !lines_hi |=> (cnt == '0));
    a_r7_start_drops_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !clr_i) |=> !idle_o);
endmodule

// File: rtl/bus_join_seq.sv
// Top level of the bus join sequencer.
// Synchronizes its asynchronous inputs, fetches the translation byte through a
// request/acknowledge handshake, waits until both segments are quiet, and only then
// closes the links and raises ready. A low enable or a high undervoltage flag forces
// a shutdown.
// Assumes the sampler holds cfg_byte_i valid during the cycle in which cfg_ack_i is high.
module bus_join_seq
    import bus_join_seq_pkg::*;
#(
    parameter int CLK_HZ   = 200_000_000,
    parameter int IDLE_US  = 120,
    parameter int SYNC_STG = 2,
    parameter int BYTE_W   = 7,
    localparam int IDLE_CYC = (CLK_HZ / 1000) * IDLE_US / 1000,
    localparam int SEGS     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              uv_i,
    input  logic              scl_up_i,
    input  logic              sda_up_i,
    input  logic              scl_dn_i,
    input  logic              sda_dn_i,
    output logic              cfg_req_o,
    input  logic              cfg_ack_i,
    input  logic [BYTE_W-1:0] cfg_byte_i,
    output logic [BYTE_W-1:0] xlat_byte_o,
    output logic              xlat_en_o,
    output logic              scl_link_o,
    output logic              sda_link_o,
    output logic              ready_o
);
    logic [5:0]      raw_in, sync_q;
    logic            en_s, uv_s, halt;
    logic [SEGS-1:0] scl_s, sda_s, idle_seg;
    seq_state_t      state;

    assign raw_in = {uv_i, en_i, scl_up_i, sda_up_i, scl_dn_i, sda_dn_i};

    bjs_sync #(.W(6), .STAGES(SYNC_STG), .RST_VAL(6'b10_1111)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_in),
        .q_o   (sync_q)
    );

    assign uv_s  = sync_q[5];
    assign en_s  = sync_q[4];
    assign scl_s = {sync_q[3], sync_q[1]};
    assign sda_s = {sync_q[2], sync_q[0]};
    assign halt  = !en_s || uv_s;

    generate
        for (genvar g = 0; g < SEGS; g++) begin : g_seg
            bjs_seg_idle #(.IDLE_CYC(IDLE_CYC)) u_idle (
                .clk    (clk),
                .rst_n  (rst_n),
                .clr_i  (state == SQ_OFF),
                .scl_i  (scl_s[g]),
                .sda_i  (sda_s[g]),
                .idle_o (idle_seg[g])
            );
        end
    endgenerate

    // Sequence state and byte capture; shutdown overrides everything.
    always_ff @(posedge clk) begin
        if (!rst_n || halt) begin
            state       <= SQ_OFF;
            xlat_byte_o <= '0;
        end else begin
            case (state)
                SQ_OFF:  state <= SQ_CFG;
                SQ_CFG:  if (cfg_ack_i) begin
                             xlat_byte_o <= cfg_byte_i;
                             state       <= SQ_WAIT;
                         end
                SQ_WAIT: if (&idle_seg) state <= SQ_ON;
                default: state <= SQ_ON;
            endcase
        end
    end

    // Outputs decoded from the registered state.
    always_comb begin
        cfg_req_o  = (state == SQ_CFG);
        ready_o    = (state == SQ_ON);
        scl_link_o = (state == SQ_ON);
        sda_link_o = (state == SQ_ON);
        xlat_en_o  = (state == SQ_ON);
    end

    a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req_o && !cfg_ack_i && !halt) |=> cfg_req_o);
    a_r3_byte_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && $past(ready_o)) |-> $stable(xlat_byte_o));
    a_r4_join_needs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> $past(&idle_seg));
    a_r8_halt_opens: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (!ready_o && !scl_link_o && !sda_link_o && !xlat_en_o
                  && xlat_byte_o == '0));
endmodule

// File: tb/bus_join_seq_bench.sv
`timescale 1ns/1ps
module bus_join_seq_bench;
    localparam int CLK_HZ  = 1_000_000;
    localparam int IDLE_US = 16;

    typedef struct packed {
        logic       en, uv, scl_u, sda_u, scl_d, sda_d, ack;
        logic [6:0] cfg_val;
        logic [7:0] cyc;
        logic       rdy, req;
        logic [6:0] exp_val;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,7'h00, 8'd4, 1'b0,1'b0,7'h00}, // R1 idle off
        '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,7'h00, 8'd5, 1'b0,1'b1,7'h00}, // R2 request
        '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,7'h2A, 8'd2, 1'b0,1'b0,7'h2A}, // R3 capture
        '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,7'h00, 8'd4, 1'b0,1'b0,7'h2A}, // R6 not yet
        '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,7'h00, 8'd12,1'b1,1'b0,7'h2A}, // R6 joined
        '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,7'h55, 8'd4, 1'b1,1'b0,7'h2A}, // R3 ignored
        '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,7'h00, 8'd4, 1'b0,1'b0,7'h00}, // R8 enable low
        '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,7'h00, 8'd5, 1'b0,1'b1,7'h00}, // R9 restart
        '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,7'h11, 8'd2, 1'b0,1'b0,7'h11}, // R9 new byte
        '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,7'h00, 8'd30,1'b0,1'b0,7'h11}, // R4 upstream busy
        '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,7'h00, 8'd3, 1'b0,1'b0,7'h11}, // R5 pre-stop
        '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,7'h00, 8'd5, 1'b1,1'b0,7'h11}, // R5 stop joins
        '{1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,7'h00, 8'd4, 1'b0,1'b0,7'h00}, // R8 undervoltage
        '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,7'h00, 8'd5, 1'b0,1'b1,7'h00}  // R10 uv clears
    };

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       en = 1'b0, uv = 1'b0, scl_u = 1'b1, sda_u = 1'b1, scl_d = 1'b1, sda_d = 1'b1;
    logic       ack = 1'b0;
    logic [6:0] cfg_val = '0;
    logic       req, xen, sl, dl, rdy;
    logic [6:0] xbyte;
    int         n_chk = 0, n_fail = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    bus_join_seq #(.CLK_HZ(CLK_HZ), .IDLE_US(IDLE_US)) u_bus_join_seq (
        .clk(clk), .rst_n(rst_n), .en_i(en), .uv_i(uv),
        .scl_up_i(scl_u), .sda_up_i(sda_u), .scl_dn_i(scl_d), .sda_dn_i(sda_d),
        .cfg_req_o(req), .cfg_ack_i(ack), .cfg_byte_i(cfg_val),
        .xlat_byte_o(xbyte), .xlat_en_o(xen), .scl_link_o(sl), .sda_link_o(dl),
        .ready_o(rdy)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 ready", rdy, 0);
        chk("R1 req", req, 0);
        chk("R1 links", {sl, dl, xen}, 0);
        chk("R1 byte", xbyte, 0);

        for (int i = 0; i < NV; i++) begin
            en = TBL[i].en; uv = TBL[i].uv;
            scl_u = TBL[i].scl_u; sda_u = TBL[i].sda_u;
            scl_d = TBL[i].scl_d; sda_d = TBL[i].sda_d;
            ack = TBL[i].ack; cfg_val = TBL[i].cfg_val;
            step(int'(TBL[i].cyc));
            chk($sformatf("R4 ready vec %0d", i), rdy, TBL[i].rdy);
            chk($sformatf("R4 links vec %0d", i), {sl, dl, xen}, {3{TBL[i].rdy}});
            chk($sformatf("R2 req vec %0d", i), req, TBL[i].req);
            chk($sformatf("R3 byte vec %0d", i), xbyte, TBL[i].exp_val);
        end

        // R2: request held with no acknowledge
        step(10);
        chk("R2 req held", req, 1);
        chk("R2 not ready", rdy, 0);

        // R6: timer expiry and restart on a brief low
        scl_d = 1'b0;
        ack = 1'b1; cfg_val = 7'h7F;
        step(2);
        ack = 1'b0;
        step(2);
        scl_d = 1'b1;
        step(10);
        chk("R6 before expiry", rdy, 0);
        scl_d = 1'b0;
        step(2);
        scl_d = 1'b1;
        step(12);
        chk("R6 restarted count", rdy, 0);
        step(10);
        chk("R6 joined after count", rdy, 1);
        chk("R9 byte", xbyte, 7'h7F);

        // R7: START withdraws quiet status
        en = 1'b0;
        step(4);
        chk("R8 enable low opens", {rdy, sl, dl, xen}, 0);
        sda_u = 1'b0;
        scl_d = 1'b0;
        en = 1'b1;
        step(5);
        ack = 1'b1; cfg_val = 7'h05;
        step(2);
        ack = 1'b0;
        sda_u = 1'b1;
        step(4);
        sda_u = 1'b0;
        step(3);
        scl_d = 1'b1;
        step(25);
        chk("R7 start keeps links open", rdy, 0);
        sda_u = 1'b1;
        step(5);
        chk("R5 stop after start joins", rdy, 1);
        chk("R3 byte kept", xbyte, 7'h05);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule